// File: doc/BRIEF.md
# Half-Row Key Matrix Scanner

This block plays the keyboard side of a scanned key matrix of nine rows by eight columns. A host sees the matrix through one combined select/clock line and four data lines. The level of the select line picks which half of the current row's eight columns is shown on the data lines. Each rising edge of the same line moves an internal ten-step row counter forward by one. The tenth step is a blank row that always reads as no keys pressed, and after it the count wraps to the first row. A separate scan-reset input returns the counter to the first row.

The key states come in on a flat parallel port, with one bit per key. The select/clock line and the scan-reset line are asynchronous to the system clock, so each passes through a two-flop synchroniser before it is used. A one-cycle edge detector then finds the rising edges of the select line. The data outputs are registered, so that the row and the half-row select change on them in the same clock cycle.

Top module: `halfrow_key_scanner`

## Requirements
- R1: Key (row r, column c) is bit r*8+c of `key_state`, with rows 0..8 and columns 0..7; a pressed key is 1 and shows as 1 on `data_out`.
- R2: With the synchronised select level low, `data_out[i]` shows column i of the current row (columns 0..3); with it high, `data_out[i]` shows column 4+i (columns 4..7).
- R3: The row counter does not change without a rising edge of the select line; a falling edge, or a level held for any time, does not move it.
- R4: Each rising edge of the select line advances the row counter by exactly one step, through steps 0..9 in order.
- R5: Step 9 is a blank row: `data_out` reads 0 there whatever `key_state` holds, and the next rising edge returns the counter to row 0.
- R6: While the synchronised `scan_rst` is high, the counter is forced to and held at row 0, and rising edges of the select line are ignored.
- R7: `sel_clk` and `scan_rst` each pass through two synchroniser flops, and `data_out` is a register. A change on either input is visible on `data_out` at the third rising clock edge after the change, with the new row and the new half appearing together.
- R8: While `rst_n` is low, the row counter is 0 and `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| scan_rst | input | 1 | Asynchronous scan reset; returns the counter to row 0 |
| sel_clk | input | 1 | Combined input: its level selects the half-row and its rising edge advances the row |
| key_state | input | 72 | Key states, bit r*8+c, 1 = pressed |
| data_out | output | 4 | Registered half-row of the current row |

## Verification
On every cycle, the assertions check several properties of the row counter. They check that it stays inside its ten steps, advances by exactly one step on each detected edge and wraps after step 9. They also check that it holds when there is no edge and is forced to row 0 under scan reset. In addition, they check that the edge pulse lasts one cycle and that the blank step yields zero data. The bench's sweeps show the things that depend on the mapping from keys to bits and on the level of the select line. These are the exact bit mapping for each half of every row under several key patterns, and the wrap over more than one full scan cycle. They also include edges being ignored during a scan reset, and a long-held level leaving the output unchanged.

// File: rtl/hks_pkg.sv
package hks_pkg;

  // Step that follows cur in a counter of `steps` states.
  function automatic int unsigned hks_next_step(input int unsigned cur,
                                                input int unsigned steps);
    return (cur + 1 >= steps) ? 0 : cur + 1;
  endfunction

  // Flat bit index of the first column shown for a row and select level.
  function automatic int unsigned hks_half_base(input int unsigned row,
                                                input int unsigned cols,
                                                input logic        hi);
    return row * cols + (hi ? cols / 2 : 0);
  endfunction

endpackage

// File: rtl/hks_sync.sv
module hks_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/hks_edge.sv
module hks_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;

  assign rise_o = level_i & ~prev_q;

  // R4: a detected edge lasts one cycle only
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hks_row_counter.sv
module hks_row_counter
  import hks_pkg::*;
#(
  parameter int STEPS = 10,
  localparam int ROW_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_q,
  output logic [ROW_W-1:0] row_next
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(STEPS - 1);

  always_comb begin
    if (clr_i)      row_next = '0;
    else if (adv_i) row_next = ROW_W'(hks_next_step(int'(row_q), STEPS));
    else            row_next = row_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) row_q <= '0;
    else        row_q <= row_next;

  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= LAST);
  a_r4_advance_one: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && row_q != LAST) |=> (row_q == $past(row_q) + 1'b1));
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && row_q == LAST) |=> (row_q == '0));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(row_q));
  a_r6_scan_reset: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (row_q == '0));
endmodule

// File: rtl/hks_half_out.sv
module hks_half_out
  import hks_pkg::*;
#(
  parameter int ROWS = 9,
  parameter int COLS = 8,
  localparam int STEPS = ROWS + 1,
  localparam int HALF  = COLS / 2,
  localparam int ROW_W = $clog2(STEPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROW_W-1:0]     row_i,
  input  logic                 hi_i,
  input  logic [ROWS*COLS-1:0] keys_i,
  output logic [HALF-1:0]      data_q
);
  localparam logic [ROW_W-1:0] BLANK = ROW_W'(ROWS);

  logic [HALF-1:0] pick;

  always_comb begin
    pick = '0;
    if (row_i != BLANK) begin
      for (int i = 0; i < HALF; i++)
        pick[i] = keys_i[hks_half_base(int'(row_i), COLS, hi_i) + i];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) data_q <= '0;
    else        data_q <= pick;

  a_r5_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (row_i == BLANK) |=> (data_q == '0));
endmodule

// File: rtl/halfrow_key_scanner.sv
module halfrow_key_scanner #(
  parameter int ROWS = 9,
  parameter int COLS = 8,
  localparam int STEPS = ROWS + 1,
  localparam int HALF  = COLS / 2,
  localparam int ROW_W = $clog2(STEPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_rst,
  input  logic                 sel_clk,
  input  logic [ROWS*COLS-1:0] key_state,
  output logic [HALF-1:0]      data_out
);
  logic [1:0]       synced;
  logic             sel_s;
  logic             clr_s;
  logic             sel_rise;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_next;

  hks_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({scan_rst, sel_clk}), .sync_o(synced)
  );
  assign sel_s = synced[0];
  assign clr_s = synced[1];

  hks_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(sel_s), .rise_o(sel_rise)
  );

  hks_row_counter #(.STEPS(STEPS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_s), .adv_i(sel_rise),
    .row_q(row_q), .row_next(row_next)
  );

  // The output register takes the next row so that row and half change together (R7).
  hks_half_out #(.ROWS(ROWS), .COLS(COLS)) u_out (
    .clk(clk), .rst_n(rst_n), .row_i(row_next), .hi_i(sel_s),
    .keys_i(key_state), .data_q(data_out)
  );

  // R8: the count and the data are cleared while the system reset is low
  a_r8_reset_state: assert property (@(posedge clk)
    !rst_n |-> (row_q == '0 && data_out == '0));
endmodule

// File: tb/halfrow_key_scanner_test.sv
module halfrow_key_scanner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_rst = 1'b0;
  logic        sel_clk = 1'b0;
  logic [71:0] key_state = '0;
  logic [3:0]  data_out;

  int checks = 0;
  int fails  = 0;
  int model_row = 0;
  bit done = 0;

  always #5 clk = ~clk;

  halfrow_key_scanner uut (
    .clk(clk), .rst_n(rst_n), .scan_rst(scan_rst), .sel_clk(sel_clk),
    .key_state(key_state), .data_out(data_out)
  );

  function automatic logic [3:0] expect_half(input int row, input logic hi,
                                             input logic [71:0] k);
    logic [3:0] r;
    r = 4'b0000;
    if (row < 9)
      for (int c = 0; c < 8; c++)
        if ((c >= 4) == hi) r[c % 4] = k[8 * row + c];
    return r;
  endfunction

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (data_out !== exp) begin
      fails++;
      $display("FAIL %s: data_out=%b expected=%b (model row %0d)", req, data_out, exp, model_row);
    end
  endtask

  // One full select pulse: the rising edge advances, and each half is checked.
  task automatic pulse_and_check(input string req);
    sel_clk = 1'b1;
    model_row = (model_row + 1) % 10;
    settle();
    check(req, expect_half(model_row, 1'b1, key_state));
    sel_clk = 1'b0;
    settle();
    check(req, expect_half(model_row, 1'b0, key_state));
  endtask

  function automatic logic [71:0] make_pattern(input int seed);
    logic [71:0] p;
    for (int b = 0; b < 72; b++) p[b] = (((b * 7 + seed) % 5) == 0) || (((b + seed) % 11) == 3);
    return p;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    key_state = {72{1'b1}};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", 4'b0000);
    rst_n = 1'b1;
    settle();
    check("R1 R2 row0 low", expect_half(0, 1'b0, key_state));

    // Sweep: each pattern walks more than two full scan cycles (R1 R2 R4 R5)
    for (int s = 0; s < 4; s++) begin
      key_state = (s == 3) ? {72{1'b1}} : make_pattern(s * 13 + 1);
      settle();
      check("R1", expect_half(model_row, 1'b0, key_state));
      for (int e = 0; e < 22; e++) pulse_and_check(model_row == 9 ? "R5" : "R4");
    end

    // R3: long-held high level, then long-held low level, leave the row unchanged
    key_state = make_pattern(5);
    sel_clk = 1'b1;
    model_row = (model_row + 1) % 10;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check("R3 held high", expect_half(model_row, 1'b1, key_state));
    sel_clk = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check("R3 falling edge", expect_half(model_row, 1'b0, key_state));

    // Move to row 4, then R6: a scan reset returns to row 0 and ignores edges
    while (model_row != 4) pulse_and_check("R4");
    scan_rst = 1'b1;
    settle();
    model_row = 0;
    check("R6 reset", expect_half(0, 1'b0, key_state));
    for (int e = 0; e < 3; e++) begin
      sel_clk = 1'b1; settle();
      check("R6 edge ignored", expect_half(0, 1'b1, key_state));
      sel_clk = 1'b0; settle();
      check("R6 edge ignored", expect_half(0, 1'b0, key_state));
    end
    scan_rst = 1'b0;
    settle();
    pulse_and_check("R6 resume");

    // R7: the change lands on the third clock edge and not before
    while (model_row != 2) pulse_and_check("R4");
    sel_clk = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 not yet", expect_half(2, 1'b0, key_state));
    @(posedge clk);
    @(negedge clk);
    model_row = 3;
    check("R7 third edge", expect_half(3, 1'b1, key_state));
    sel_clk = 1'b0;
    settle();

    // R8: system reset clears the output and the row
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid-run", 4'b0000);
    rst_n = 1'b1;
    model_row = 0;
    settle();
    check("R8 row0", expect_half(0, 1'b0, key_state));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule